// File: doc/BRIEF.md
# DSI Video Horizontal Word-Count Calculator

This block turns the horizontal timing of a video line, given in pixels, into the byte word counts that a DSI video-mode packetizer loads for its sync-active, back-porch and front-porch blanking packets. It also takes into account the time the D-PHY spends switching between high-speed and low-power states. That overhead is taken out of the two porches. The amount removed from each porch is proportional to that porch's share of the total blanking.

A request starts with a one-cycle `start` strobe. The block copies all of its inputs at that point. It computes the fixed terms in one cycle. The proportional split then runs through one restoring divider that is used twice, once per porch. When `done` pulses for one cycle, the three word counts and the `short_warn` flag are valid. They hold their values until the next result is written. If the blanking interval is too short to absorb the overhead, the porches keep their raw sizes and `short_warn` is raised.

Top module: `hwc_calc`

## Requirements
- R1: Bytes per pixel is 2 when `fmt_16b` is 1 and 3 when it is 0.
- R2: `hsa_wc` equals hsync*bpp - 10, clamped at zero.
- R3: The base back-porch count is hback*bpp - 10 when `pulse_en` is 1 and (hback + hsync)*bpp - 10 when it is 0, clamped at zero. With short blanking, `hbp_wc` equals this base.
- R4: The overhead is (phy_cyc + 3)*lanes + K, where K is 18 when `burst_en` is 1 and 12 otherwise. The blanking (hfront + hback)*bpp is compared against this overhead.
- R5: When the blanking exceeds the overhead, `hfp_wc` = hfront*bpp - floor(ovh*hfront/(hfront+hback)) and `hbp_wc` = base - floor(ovh*hback/(hfront+hback)). Both are clamped at zero, and `short_warn` is 0.
- R6: When the blanking does not exceed the overhead, `hfp_wc` = hfront*bpp, `hbp_wc` equals the base and `short_warn` is 1.
- R7: `start` is taken only while `busy` is 0. A `start` during a calculation has no effect on its result and produces no extra `done`. `done` is high for exactly one cycle, and the outputs hold until the next `done`.
- R8: After reset, `busy`, `done`, `short_warn` and all three word counts are 0.
- R9: Blanking exactly equal to the overhead takes the R6 path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (taken when idle) |
| hsync_px | input | PX_W | Sync-active length in pixels |
| hback_px | input | PX_W | Back-porch length in pixels |
| hfront_px | input | PX_W | Front-porch length in pixels |
| fmt_16b | input | 1 | 1: 16-bit pixel format (2 bytes/pixel) |
| lanes | input | LANE_W | Active data lane count |
| phy_cyc | input | PHY_W | Sum of PHY lpx, prepare, zero and exit cycles |
| burst_en | input | 1 | Burst video mode |
| pulse_en | input | 1 | Sync-pulse video mode |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle strobe: outputs valid |
| hsa_wc | output | WC_W | Sync-active word count |
| hbp_wc | output | WC_W | Back-porch word count |
| hfp_wc | output | WC_W | Front-porch word count |
| short_warn | output | 1 | Blanking too short to absorb PHY overhead |

## Verification
The bench sweeps sync, porch, format, lane, burst and sync-pulse combinations. It goes after the cases where hsync*bpp falls below 10 and a design that does not clamp would wrap to a huge count. It also covers zero porches: a design that divided in that case would produce garbage or a division by zero. A directed run sets the blanking exactly equal to the overhead, where an off-by-one comparison would split when it should warn. Another run pulses `start` in the middle of a calculation. A design that accepted that strobe would return the second request's numbers or pulse `done` twice.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
   typedef enum logic [1:0] {
      S_IDLE,
      S_PREP,
      S_DIV_F,
      S_DIV_B
   } hwc_state_t;

   localparam int unsigned HDR_BYTES = 10;  // packet header + footer bytes
   localparam int unsigned PHY_PAD   = 3;   // extra PHY cycles per transition
   localparam int unsigned K_BURST   = 18;
   localparam int unsigned K_EVENT   = 12;

   // subtraction that floors at zero
   function automatic logic [31:0] sub_floor(input logic [31:0] a, input logic [31:0] b);
      return (a > b) ? (a - b) : 32'd0;
   endfunction
endpackage

// File: rtl/hwc_prep.sv
module hwc_prep
   import hwc_pkg::*;
#(
   parameter int PX_W   = 12,
   parameter int PHY_W  = 10,
   parameter int LANE_W = 3,
   parameter int OVH_W  = PHY_W + LANE_W + 2
) (
   input  logic [PX_W-1:0]   hs,
   input  logic [PX_W-1:0]   hb,
   input  logic [PX_W-1:0]   hf,
   input  logic              fmt_16b,
   input  logic [LANE_W-1:0] lanes,
   input  logic [PHY_W-1:0]  phy,
   input  logic              burst,
   input  logic              pulse,
   output logic [31:0]       bpp,
   output logic [31:0]       hsa_b,
   output logic [31:0]       hbp_base,
   output logic [31:0]       hf_b,
   output logic [OVH_W-1:0]  ovh,
   output logic              room
);
   logic [31:0] hs32, hb32, hf32, ovh32, blank32;

   always_comb begin
      hs32     = 32'(hs);
      hb32     = 32'(hb);
      hf32     = 32'(hf);
      bpp      = fmt_16b ? 32'd2 : 32'd3;
      hsa_b    = sub_floor(hs32 * bpp, HDR_BYTES);
      hbp_base = pulse ? sub_floor(hb32 * bpp, HDR_BYTES)
                       : sub_floor((hb32 + hs32) * bpp, HDR_BYTES);
      hf_b     = hf32 * bpp;
      ovh32    = (32'(phy) + PHY_PAD) * 32'(lanes) + (burst ? K_BURST : K_EVENT);
      ovh      = OVH_W'(ovh32);
      blank32  = (hf32 + hb32) * bpp;
      room     = blank32 > ovh32;
   end
endmodule

// File: rtl/hwc_div.sv
module hwc_div #(
   parameter int NUM_W = 27,
   parameter int DEN_W = 13,
   parameter int STEPS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             rdy,
   output logic [NUM_W-1:0] quo
);
   localparam int ITER  = NUM_W / STEPS;
   localparam int CNT_W = $clog2(ITER + 1);
   localparam int PW    = NUM_W + DEN_W;

   generate
      if (STEPS < 1 || (NUM_W % STEPS) != 0) begin : g_bad_steps
         $error("STEPS must be positive and divide NUM_W");
      end
   endgenerate

   logic             busy;
   logic [CNT_W-1:0] cnt;
   logic [DEN_W-1:0] rem, rem_nx;
   logic [NUM_W-1:0] acc, acc_nx, num_l;
   logic [DEN_W-1:0] den_l;

   always_comb begin
      logic [DEN_W:0] t;
      acc_nx = acc;
      rem_nx = rem;
      for (int s = 0; s < STEPS; s++) begin
         t      = {rem_nx, acc_nx[NUM_W-1]};
         acc_nx = {acc_nx[NUM_W-2:0], 1'b0};
         if (t >= {1'b0, den_l}) begin
            t         = t - {1'b0, den_l};
            acc_nx[0] = 1'b1;
         end
         rem_nx = t[DEN_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt   <= '0;
         rem   <= '0;
         acc   <= '0;
         num_l <= '0;
         den_l <= '0;
         rdy   <= 1'b0;
      end else begin
         rdy <= 1'b0;
         if (go) begin
            acc   <= num;
            rem   <= '0;
            num_l <= num;
            den_l <= den;
            cnt   <= CNT_W'(ITER);
            busy  <= 1'b1;
         end else if (busy) begin
            acc <= acc_nx;
            rem <= rem_nx;
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
               busy <= 1'b0;
               rdy  <= 1'b1;
            end
         end
      end
   end

   assign quo = acc;

   AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      rdy |-> (PW'(quo) * PW'(den_l) <= PW'(num_l)) &&
              (PW'(num_l) - PW'(quo) * PW'(den_l) < PW'(den_l))); // R5
endmodule

// File: rtl/hwc_calc.sv
module hwc_calc
   import hwc_pkg::*;
#(
   parameter int PX_W      = 12,
   parameter int PHY_W     = 10,
   parameter int LANE_W    = 3,
   parameter int WC_W      = 16,
   parameter int DIV_STEPS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PX_W-1:0]   hsync_px,
   input  logic [PX_W-1:0]   hback_px,
   input  logic [PX_W-1:0]   hfront_px,
   input  logic              fmt_16b,
   input  logic [LANE_W-1:0] lanes,
   input  logic [PHY_W-1:0]  phy_cyc,
   input  logic              burst_en,
   input  logic              pulse_en,
   output logic              busy,
   output logic              done,
   output logic [WC_W-1:0]   hsa_wc,
   output logic [WC_W-1:0]   hbp_wc,
   output logic [WC_W-1:0]   hfp_wc,
   output logic              short_warn
);
   localparam int OVH_W  = PHY_W + LANE_W + 2;
   localparam int NUM_W  = OVH_W + PX_W;
   localparam int DEN_W  = PX_W + 1;
   localparam int WC_MAX = (1 << WC_W) - 1;

   generate
      if (PX_W + 3 > 31 || NUM_W > 31) begin : g_bad_width
         $error("pixel or overhead width too large for 32-bit arithmetic");
      end
      if (WC_W < 8 || WC_W > 30) begin : g_bad_wc
         $error("WC_W out of range");
      end
   endgenerate

   function automatic logic [WC_W-1:0] sat_wc(input logic [31:0] v);
      return (v > 32'(WC_MAX)) ? {WC_W{1'b1}} : v[WC_W-1:0];
   endfunction

   hwc_state_t        st;
   logic [PX_W-1:0]   hs_l, hb_l, hf_l;
   logic              fmt_l, burst_l, pulse_l;
   logic [LANE_W-1:0] lanes_l;
   logic [PHY_W-1:0]  phy_l;

   logic [31:0]       bpp, hsa_b, hbp_base, hf_b;
   logic [OVH_W-1:0]  ovh;
   logic              room;

   logic              div_go, div_rdy;
   logic [NUM_W-1:0]  div_num, div_quo, q_f;
   logic [DEN_W-1:0]  div_den;

   hwc_prep #(.PX_W(PX_W), .PHY_W(PHY_W), .LANE_W(LANE_W), .OVH_W(OVH_W)) u_prep (
      .hs(hs_l), .hb(hb_l), .hf(hf_l), .fmt_16b(fmt_l), .lanes(lanes_l),
      .phy(phy_l), .burst(burst_l), .pulse(pulse_l),
      .bpp(bpp), .hsa_b(hsa_b), .hbp_base(hbp_base), .hf_b(hf_b),
      .ovh(ovh), .room(room)
   );

   assign div_go  = ((st == S_PREP) && room) || ((st == S_DIV_F) && div_rdy);
   assign div_num = NUM_W'(ovh) * NUM_W'((st == S_PREP) ? hf_l : hb_l);
   assign div_den = DEN_W'(hf_l) + DEN_W'(hb_l);

   hwc_div #(.NUM_W(NUM_W), .DEN_W(DEN_W), .STEPS(DIV_STEPS)) u_div (
      .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
      .rdy(div_rdy), .quo(div_quo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         hs_l       <= '0;
         hb_l       <= '0;
         hf_l       <= '0;
         fmt_l      <= 1'b0;
         burst_l    <= 1'b0;
         pulse_l    <= 1'b0;
         lanes_l    <= '0;
         phy_l      <= '0;
         q_f        <= '0;
         done       <= 1'b0;
         hsa_wc     <= '0;
         hbp_wc     <= '0;
         hfp_wc     <= '0;
         short_warn <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            S_IDLE: if (start) begin
               hs_l    <= hsync_px;
               hb_l    <= hback_px;
               hf_l    <= hfront_px;
               fmt_l   <= fmt_16b;
               burst_l <= burst_en;
               pulse_l <= pulse_en;
               lanes_l <= lanes;
               phy_l   <= phy_cyc;
               st      <= S_PREP;
            end
            S_PREP: if (room) begin
               st <= S_DIV_F;
            end else begin
               hsa_wc     <= sat_wc(hsa_b);
               hbp_wc     <= sat_wc(hbp_base);
               hfp_wc     <= sat_wc(hf_b);
               short_warn <= 1'b1;
               done       <= 1'b1;
               st         <= S_IDLE;
            end
            S_DIV_F: if (div_rdy) begin
               q_f <= div_quo;
               st  <= S_DIV_B;
            end
            S_DIV_B: if (div_rdy) begin
               hsa_wc     <= sat_wc(hsa_b);
               hbp_wc     <= sat_wc(sub_floor(hbp_base, 32'(div_quo)));
               hfp_wc     <= sat_wc(sub_floor(hf_b, 32'(q_f)));
               short_warn <= 1'b0;
               done       <= 1'b1;
               st         <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy = (st != S_IDLE);

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy); // R7
   AST_HFP_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> 32'(hfp_wc) <= 32'(hf_l) * bpp); // R5
   AST_HBP_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> 32'(hbp_wc) <= (32'(hf_l) + 32'(hb_l) + 32'(hs_l)) * bpp); // R3
   AST_SPLIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == S_DIV_B) && div_rdy) |-> 32'(q_f) + 32'(div_quo) <= 32'(ovh)); // R5
   AST_INPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(hf_l) && $stable(hb_l)); // R7
endmodule

// File: tb/tb_hwc_calc.sv
`timescale 1ns/1ps
module tb_hwc_calc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [11:0] hsync_px = '0, hback_px = '0, hfront_px = '0;
   logic        fmt_16b = 1'b0;
   logic [2:0]  lanes = '0;
   logic [9:0]  phy_cyc = '0;
   logic        burst_en = 1'b0, pulse_en = 1'b0;
   logic        busy, done, short_warn;
   logic [15:0] hsa_wc, hbp_wc, hfp_wc;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   hwc_calc dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .hsync_px(hsync_px), .hback_px(hback_px), .hfront_px(hfront_px),
      .fmt_16b(fmt_16b), .lanes(lanes), .phy_cyc(phy_cyc),
      .burst_en(burst_en), .pulse_en(pulse_en),
      .busy(busy), .done(done), .hsa_wc(hsa_wc), .hbp_wc(hbp_wc),
      .hfp_wc(hfp_wc), .short_warn(short_warn)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int fl(input int v);
      return (v < 0) ? 0 : v;
   endfunction

   // arithmetic reference taken from the requirements
   task automatic model(input int hs, hb, hf, f, ln, phy, bu, sp,
                        output int e_hsa, e_hbp, e_hfp, e_warn);
      int bpp, base, ovh, blank;
      bpp   = f ? 2 : 3;                                   // R1
      e_hsa = fl(hs * bpp - 10);                           // R2
      base  = sp ? fl(hb * bpp - 10) : fl((hb + hs) * bpp - 10); // R3
      ovh   = (phy + 3) * ln + (bu ? 18 : 12);             // R4
      blank = (hf + hb) * bpp;
      if (blank > ovh) begin                               // R5
         e_hfp  = fl(hf * bpp - (ovh * hf) / (hf + hb));
         e_hbp  = fl(base - (ovh * hb) / (hf + hb));
         e_warn = 0;
      end else begin                                       // R6
         e_hfp  = hf * bpp;
         e_hbp  = base;
         e_warn = 1;
      end
   endtask

   task automatic drive(input int hs, hb, hf, f, ln, phy, bu, sp);
      hsync_px  = 12'(hs);
      hback_px  = 12'(hb);
      hfront_px = 12'(hf);
      fmt_16b   = f[0];
      lanes     = 3'(ln);
      phy_cyc   = 10'(phy);
      burst_en  = bu[0];
      pulse_en  = sp[0];
   endtask

   task automatic wait_done(output bit ok);
      int n = 0;
      while (!done && n < 3000) begin
         @(negedge clk);
         n++;
      end
      ok = done;
      if (!ok) chk(1'b0, "R7 watchdog: done never seen", 0, 1);
   endtask

   task automatic run(input int hs, hb, hf, f, ln, phy, bu, sp);
      int e_hsa, e_hbp, e_hfp, e_warn;
      bit ok;
      logic [15:0] held;
      model(hs, hb, hf, f, ln, phy, bu, sp, e_hsa, e_hbp, e_hfp, e_warn);
      @(negedge clk);
      drive(hs, hb, hf, f, ln, phy, bu, sp);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      if (ok) begin
         chk(int'(hsa_wc) == e_hsa, "R1 R2 hsa_wc", int'(hsa_wc), e_hsa);
         chk(int'(short_warn) == e_warn, "R4 short_warn", int'(short_warn), e_warn);
         if (e_warn != 0) begin
            chk(int'(hbp_wc) == e_hbp, "R3 R6 hbp_wc", int'(hbp_wc), e_hbp);
            chk(int'(hfp_wc) == e_hfp, "R6 hfp_wc", int'(hfp_wc), e_hfp);
         end else begin
            chk(int'(hbp_wc) == e_hbp, "R3 R5 hbp_wc", int'(hbp_wc), e_hbp);
            chk(int'(hfp_wc) == e_hfp, "R5 hfp_wc", int'(hfp_wc), e_hfp);
         end
         held = hfp_wc;
         @(negedge clk);
         chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
         chk(hfp_wc == held, "R7 output hold", int'(hfp_wc), int'(held));
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int hs_v[4] = '{0, 3, 4, 20};
      int hb_v[4] = '{0, 2, 7, 40};
      int hf_v[4] = '{0, 1, 9, 60};
      int e_hsa, e_hbp, e_hfp, e_warn, dones;
      bit ok;

      repeat (3) @(negedge clk);
      // R8: reset state
      chk(busy == 1'b0, "R8 busy", int'(busy), 0);
      chk(done == 1'b0, "R8 done", int'(done), 0);
      chk(short_warn == 1'b0, "R8 short_warn", int'(short_warn), 0);
      chk(hsa_wc == 16'd0, "R8 hsa_wc", int'(hsa_wc), 0);
      chk(hbp_wc == 16'd0, "R8 hbp_wc", int'(hbp_wc), 0);
      chk(hfp_wc == 16'd0, "R8 hfp_wc", int'(hfp_wc), 0);
      rst_n = 1'b1;

      // near-exhaustive sweep of a small configuration
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++)
               for (int m = 0; m < 16; m++)
                  run(hs_v[a], hb_v[b], hf_v[c], m & 1, ((m >> 3) & 1) ? 4 : 1,
                      5, (m >> 1) & 1, (m >> 2) & 1);

      // R9: blanking equal to overhead: ovh=(5+3)*1+12=20, (4+6)*2=20
      run(2, 6, 4, 1, 1, 5, 0, 0);
      chk(short_warn == 1'b1, "R9 equal blanking warns", int'(short_warn), 1);
      // one above: (4+3)*3=21 > 20
      run(2, 3, 4, 0, 1, 5, 0, 0);
      chk(short_warn == 1'b0, "R9 one above splits", int'(short_warn), 0);
      // large values, burst, many lanes
      run(4095, 4095, 4095, 0, 7, 1023, 1, 0);
      run(100, 300, 200, 0, 4, 40, 1, 1);

      // R7: start during a calculation is ignored
      model(10, 50, 80, 0, 2, 20, 0, 0, e_hsa, e_hbp, e_hfp, e_warn);
      @(negedge clk);
      drive(10, 50, 80, 0, 2, 20, 0, 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      drive(1, 1, 1, 1, 1, 1, 1, 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      if (ok) begin
         chk(int'(hfp_wc) == e_hfp, "R7 ignored start hfp_wc", int'(hfp_wc), e_hfp);
         chk(int'(hbp_wc) == e_hbp, "R7 ignored start hbp_wc", int'(hbp_wc), e_hbp);
         chk(int'(hsa_wc) == e_hsa, "R7 ignored start hsa_wc", int'(hsa_wc), e_hsa);
      end
      dones = 0;
      for (int i = 0; i < 150; i++) begin
         @(negedge clk);
         if (done) dones++;
      end
      chk(dones == 0, "R7 no extra done", dones, 0);
      chk(busy == 1'b0, "R7 idle after ignored start", int'(busy), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule